// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block sequences conversions for an eight-input successive-approximation converter. Software sees it as two byte-wide registers on a small read/write port. One is the result register, at address 0. The other is the control register, at address 1. The control register holds the channel number and a single flag bit. That bit serves both as the start command and as the completion indicator. The analog front end is not part of the block: each channel's value arrives on its own 8-bit lane of a flat input bus.

To start a conversion, software writes the control register with the flag bit clear. The flag then reads 0. A counter runs for a fixed number of clocks, 50 by default. When it expires, the block does three things: it captures the selected lane into the result register, sets the flag, and raises the interrupt request. A read of the result register returns the captured value and withdraws the request.

A two-state machine sits at the core. In `ST_IDLE` nothing is counting. A start (transition START) moves it to `ST_CONVERT` with the count at zero. In `ST_CONVERT` the count advances once per clock. A start seen in this state (transition RESTART) stays in `ST_CONVERT` and zeroes the count. When the last count is reached with no start present (transition FINISH), the machine returns to `ST_IDLE` and issues the one-cycle completion event.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the result register reads 0x00, the interrupt request is low, and no conversion is running.
- R2: A read at address 1 returns the control register: bits [2:0] hold the channel number, bit 3 holds the flag, and bits [7:4] read back exactly as last written, with no function. When the read strobe is low, the read data is 0x00.
- R3: A write to address 1 with bit 3 = 0 starts a conversion on the channel given in bits [2:0], and the flag reads 0 from the next cycle.
- R4: A conversion completes exactly 50 clock edges after the edge that accepted the start write. Completion sets the flag and raises the interrupt request; neither changes at any earlier edge.
- R5: At completion the lane of the channel selected in that cycle is captured. A read at address 0 returns the captured value, and later changes on the sample inputs do not alter it.
- R6: A read at address 0 clears the interrupt request at that clock edge. A read at address 1 leaves the request unchanged.
- R7: A write to address 0 changes neither the control register, the result register nor the interrupt request.
- R8: A start written while a conversion is running restarts the 50-cycle count from zero. The earlier conversion then never completes.
- R9: A write to address 1 with bit 3 = 1 stores the written value but starts no conversion. If the block was idle, no completion follows.
- R10: If a completion and a read at address 0 fall on the same clock edge, the interrupt request ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | Register address: 0 = result, 1 = control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 0 acknowledges the interrupt |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational; 0x00 when reg_rd is low |
| ch_samples | input | 64 | Eight 8-bit channel lanes; channel n occupies bits [8n+7:8n] |
| adc_irq | output | 1 | Conversion-complete interrupt request (level) |

## Verification
The assertions check, on every cycle, the machine's local stepping:
- a start always lands in `ST_CONVERT` with the count at zero;
- each converting cycle without a start advances the count by exactly one;
- the last count returns the machine to idle;
- completion sets the flag and the request on the following edge;
- a result read clears the request unless a completion coincides with it;
- the captured result equals the lane selected at completion.

Only the bench's scenarios can show the end-to-end properties:
- the full 50-cycle latency, measured from the write at the port;
- that a restart really delays completion by the time already spent;
- that the captured value survives later changes on the inputs;
- that writes to the result address and flag-set writes have no visible effect.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    // Register geometry
    localparam int REG_W    = 8;
    localparam int FLAG_BIT = 3;

    // Register addresses on the one-bit address port
    localparam logic ADDR_RESULT  = 1'b0;
    localparam logic ADDR_CONTROL = 1'b1;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_CONVERT = 1'b1
    } conv_state_t;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_ctrl_pkg::*;
#(
    parameter int CONV_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic finish_o
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    conv_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             finish_d;

    // Next-state and output logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        finish_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin            // START
                    state_d = ST_CONVERT;
                    cnt_d   = '0;
                end
            end
            ST_CONVERT: begin
                if (start_i) begin            // RESTART
                    cnt_d = '0;
                end else if (cnt_q == LAST_CNT) begin  // FINISH
                    state_d  = ST_IDLE;
                    cnt_d    = '0;
                    finish_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE_CNT;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign finish_o = finish_d;

    // R3
    start_enters_convert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_CONVERT && cnt_q == '0));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !start_i && cnt_q != LAST_CNT)
            |=> (state_q == ST_CONVERT && cnt_q == $past(cnt_q) + ONE_CNT));

    // R4
    last_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !start_i && cnt_q == LAST_CNT) |=> (state_q == ST_IDLE));

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             finish_i,
    input  logic             result_rd_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic             irq_o,
    output logic             start_o
);

    logic [REG_W-1:0] ctrl_q;
    logic             irq_q;

    // A control write with the flag clear is the start command
    assign start_o = ctrl_wr_i && !wdata_i[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr_i) begin
            ctrl_q <= wdata_i;
        end else if (finish_i) begin
            ctrl_q[FLAG_BIT] <= 1'b1;
        end
    end

    // Completion outranks an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (finish_i) begin
            irq_q <= 1'b1;
        end else if (result_rd_i) begin
            irq_q <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = irq_q;

    // R4
    finish_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> (ctrl_q[FLAG_BIT] && irq_q));

    // R6
    read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd_i && !finish_i) |=> !irq_q);

    // R10
    finish_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd_i && finish_i) |=> irq_q);

    // R3
    start_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !ctrl_q[FLAG_BIT]);

    // R7
    quiet_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr_i && !finish_i && !result_rd_i) |=> ($stable(ctrl_q) && $stable(irq_q)));

endmodule

// File: rtl/adc_sample_latch.sv
module adc_sample_latch #(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0]   samples_i,
    input  logic [$clog2(NUM_CH)-1:0]    chan_i,
    input  logic                         capture_i,
    output logic [SAMPLE_W-1:0]          result_o
);

    logic [SAMPLE_W-1:0] lane [NUM_CH];
    logic [SAMPLE_W-1:0] sel_sample;
    logic [SAMPLE_W-1:0] result_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign lane[g] = samples_i[g*SAMPLE_W +: SAMPLE_W];
    end

    assign sel_sample = lane[chan_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (capture_i) begin
            result_q <= sel_sample;
        end
    end

    assign result_o = result_q;

    // R5
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (result_q == $past(samples_i[chan_i*SAMPLE_W +: SAMPLE_W])));

    // R5
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(result_q));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SAMPLE_W    = 8,
    parameter int CONV_CYCLES = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_addr,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    input  logic [NUM_CH*SAMPLE_W-1:0] ch_samples,
    output logic                       adc_irq
);

    localparam int CH_W = $clog2(NUM_CH);

    logic             ctrl_wr;
    logic             result_rd;
    logic             start;
    logic             finish;
    logic [REG_W-1:0] ctrl;
    logic [SAMPLE_W-1:0] result;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CONTROL);
    assign result_rd = reg_rd && (reg_addr == ADDR_RESULT);

    adc_ctrl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (ctrl_wr),
        .wdata_i     (reg_wdata),
        .finish_i    (finish),
        .result_rd_i (result_rd),
        .ctrl_o      (ctrl),
        .irq_o       (adc_irq),
        .start_o     (start)
    );

    adc_seq_fsm #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .finish_o (finish)
    );

    adc_sample_latch #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .samples_i (ch_samples),
        .chan_i    (ctrl[CH_W-1:0]),
        .capture_i (finish),
        .result_o  (result)
    );

    always_comb begin
        if (!reg_rd) begin
            reg_rdata = '0;
        end else if (reg_addr == ADDR_CONTROL) begin
            reg_rdata = ctrl;
        end else begin
            reg_rdata = REG_W'(result);
        end
    end

endmodule

// File: tb/adc_conv_ctrl_test.sv
module adc_conv_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_addr = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [63:0] ch_samples = '0;
    logic        adc_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    adc_conv_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ch_samples (ch_samples),
        .adc_irq    (adc_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Look at a register without letting a clock edge see the strobe
    task automatic peek(input logic a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        reg_rd = 1'b0;
    endtask

    // Read that spans one edge (acknowledges on address 0)
    task automatic read_reg(input logic a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic void set_lane(input int ch, input logic [7:0] v);
        ch_samples[ch*8 +: 8] = v;
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        peek(1'b1, v); check("R1 control after reset", v, 8'h00);
        peek(1'b0, v); check("R1 result after reset", v, 8'h00);
        check("R1 irq after reset", {7'b0, adc_irq}, 8'h00);
        check("R2 idle read data", reg_rdata, 8'h00);
    endtask

    task automatic t_latency;
        logic [7:0] v;
        set_lane(5, 8'hA5);
        write_reg(1'b1, 8'h05);
        peek(1'b1, v); check("R3 flag cleared on start", v, 8'h05);
        wait_clk(49);
        peek(1'b1, v); check("R4 no completion at edge 49", v, 8'h05);
        check("R4 irq low at edge 49", {7'b0, adc_irq}, 8'h00);
        wait_clk(1);
        peek(1'b1, v); check("R4 flag set at edge 50", v, 8'h0D);
        check("R4 irq high at edge 50", {7'b0, adc_irq}, 8'h01);
        set_lane(5, 8'h3C);
        read_reg(1'b1, v); check("R2 control read", v, 8'h0D);
        check("R6 control read keeps irq", {7'b0, adc_irq}, 8'h01);
        read_reg(1'b0, v); check("R5 captured sample kept", v, 8'hA5);
        check("R6 result read clears irq", {7'b0, adc_irq}, 8'h00);
    endtask

    task automatic t_channels;
        logic [7:0] v;
        set_lane(0, 8'h11); set_lane(7, 8'hEE);
        write_reg(1'b1, 8'hF0);
        wait_clk(50);
        read_reg(1'b0, v); check("R5 channel 0 sample", v, 8'h11);
        peek(1'b1, v); check("R2 upper bits kept", v, 8'hF8);
        write_reg(1'b1, 8'h07);
        wait_clk(50);
        read_reg(1'b0, v); check("R5 channel 7 sample", v, 8'hEE);
    endtask

    task automatic t_data_write;
        logic [7:0] v;
        write_reg(1'b1, 8'h02);
        wait_clk(50);
        write_reg(1'b0, 8'hFF);
        peek(1'b1, v); check("R7 control after result write", v, 8'h0A);
        peek(1'b0, v); check("R7 result after result write", v, {ch_samples[23:16]});
        check("R7 irq after result write", {7'b0, adc_irq}, 8'h01);
        read_reg(1'b0, v);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        set_lane(3, 8'h5A);
        write_reg(1'b1, 8'h03);
        wait_clk(20);
        write_reg(1'b1, 8'h03);
        wait_clk(49);
        peek(1'b1, v); check("R8 old conversion did not finish", v, 8'h03);
        check("R8 irq low before restart ends", {7'b0, adc_irq}, 8'h00);
        wait_clk(1);
        peek(1'b1, v); check("R8 restarted conversion finishes", v, 8'h0B);
        read_reg(1'b0, v); check("R8 restarted sample", v, 8'h5A);
    endtask

    task automatic t_no_start;
        logic [7:0] v;
        write_reg(1'b1, 8'h0B);
        peek(1'b1, v); check("R9 flag-set write stored", v, 8'h0B);
        wait_clk(60);
        check("R9 no completion follows", {7'b0, adc_irq}, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        set_lane(1, 8'h77);
        write_reg(1'b1, 8'h01);
        wait_clk(49);
        read_reg(1'b0, v);
        check("R10 irq set when finish meets ack", {7'b0, adc_irq}, 8'h01);
        read_reg(1'b0, v); check("R10 sample after collision", v, 8'h77);
        check("R6 irq cleared after second read", {7'b0, adc_irq}, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) set_lane(i, 8'(8'h20 + i));
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_latency();
        t_channels();
        t_data_write();
        t_restart();
        t_no_start();
        t_collide();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule